// File: doc/BRIEF.md
# NAND Flash Command Front End

This block is the device-side bus front end of a NAND flash device. It watches the multiplexed 8-bit bus and takes one byte on each rising edge of the write strobe while the chip enable is low. The latch enables tell command bytes from address bytes. From these bytes the block tracks two-part command sequences and fills in the column and row address bytes. When a sequence ends with its confirm byte, it sends a one-cycle operation strobe to the separate cell-array model. The strobe carries the operation code and the assembled addresses.

Address limits are checked when an operation is confirmed. A ready/busy line follows a per-operation busy time, and that time is set by parameters. While the block is busy it takes only a reset or a status request. The read strobe returns either a status byte or the identification bytes, depending on the last output-select command.

Top module: `nand_cmd_top`

## Requirements
- R1: A byte is taken only on a clock where `weN` is high after being low on the previous clock, with `ceN` low. The byte is a command when only `cleIn` is high and an address when only `aleIn` is high. A byte taken with both latch enables high, or with `ceN` high, has no effect. Every strobe except random-input is caused by a command byte.
- R2: Address bytes are taken in this order: column low, column high, row low, row middle, row high (`colAddr` = {high, low}, `rowAddr` = {high, middle, low}). The sequence 00h, 5 address bytes, 30h gives strobe `opKind` 1 (page read). Ending with 35h instead gives `opKind` 2 (read for internal copy).
- R3: The sequence 80h, 5 address bytes, any data bytes, 10h gives `opKind` 3 (program). Ending with 15h gives `opKind` 4 (cache program). The sequence 85h, 5 address bytes, 10h gives `opKind` 5 (copy program).
- R4: Inside a program sequence, after its address bytes, 85h followed by 2 column bytes gives a strobe with `opKind` 7 (random input). The program sequence then goes on and awaits its confirm. The sequence 05h, 2 column bytes, E0h gives `opKind` 8 (random output). In both cases `rowAddr` keeps its prior value, and neither sets busy.
- R5: The sequence 60h, 3 row bytes, D0h gives `opKind` 6 (block erase) and leaves `colAddr` unchanged.
- R6: While `rdyBusyN` is low, only FFh and 70h have an effect. All other command, address and data bytes are ignored.
- R7: An opcode outside the defined set does nothing in idle. An unexpected opcode during a sequence aborts the sequence, and this includes a confirm that arrives before all address bytes. The opcode that caused the abort does not start a new operation.
- R8: FFh aborts any state at once, even while busy. It gives `opKind` 9 (reset) and holds busy for `BUSY_RESET` cycles.
- R9: A confirmed operation with a column above `COL_MAX` or a row above `ROW_MAX` gives no strobe and no busy, and sets `addrErr`. Erase checks only the row, and the random operations check only the column. The next accepted operation or reset clears `addrErr`.
- R10: After 70h, each read of `dataOut` (while `reN` is low) returns status. Bit 6 is not-busy, bit 0 is `addrErr`, and the other bits are 0. This holds until another accepted command.
- R11: After 90h and one address byte, successive `reN` pulses return the `ID_BYTES` bytes of `ID_CODE` lowest byte first, wrapping round. When no output is selected, `dataOut` is 0.
- R12: The strobe and the fall of `rdyBusyN` appear on the clock after the confirm byte is taken. Busy then lasts exactly the parameter cycles for the operation: read kinds `BUSY_READ`, program and copy program `BUSY_PROG`, cache `BUSY_CACHE`, erase `BUSY_ERASE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| ceN | input | 1 | Chip enable, active low |
| cleIn | input | 1 | Command latch enable |
| aleIn | input | 1 | Address latch enable |
| weN | input | 1 | Write strobe, byte taken on its rise |
| reN | input | 1 | Read strobe, output advances on its rise |
| ioIn | input | 8 | Bus byte in |
| dataOut | output | 8 | Status or identification byte |
| rdyBusyN | output | 1 | High when ready |
| opValid | output | 1 | One-cycle operation strobe |
| opKind | output | 4 | Operation code with the strobe |
| colAddr | output | 16 | Assembled column |
| rowAddr | output | 24 | Assembled row |
| addrErr | output | 1 | Last confirmed operation had an out-of-range address |

## Verification
The main decode is driven with random sequences of the six array operations. Their columns and rows are drawn to fall both inside and just outside the limits. This separates a correct range check from one that is off by one or that tests the wrong field for erase, and it checks that each operation's busy time is its own. Directed sequences cover the cases that random traffic cannot reach. These are confirms sent while busy, early confirms and stray opcodes, reset in the middle of a sequence and during busy, the random column operations that must keep the row, and the status and identification output modes with their persistence and wrap.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

  localparam int COL_BYTES  = 2;
  localparam int ROW_BYTES  = 3;
  localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
  localparam int COL_W      = 8 * COL_BYTES;
  localparam int ROW_W      = 8 * ROW_BYTES;
  localparam int ADDR_W     = COL_W + ROW_W;
  localparam int SLOT_W     = $clog2(ADDR_BYTES);

  localparam logic [7:0] CMD_RD_SETUP  = 8'h00;
  localparam logic [7:0] CMD_RD_GO     = 8'h30;
  localparam logic [7:0] CMD_RD_CB_GO  = 8'h35;
  localparam logic [7:0] CMD_PG_SETUP  = 8'h80;
  localparam logic [7:0] CMD_PG_GO     = 8'h10;
  localparam logic [7:0] CMD_PG_CACHE  = 8'h15;
  localparam logic [7:0] CMD_COL_IN    = 8'h85;
  localparam logic [7:0] CMD_COL_OUT   = 8'h05;
  localparam logic [7:0] CMD_COL_OUTGO = 8'hE0;
  localparam logic [7:0] CMD_ER_SETUP  = 8'h60;
  localparam logic [7:0] CMD_ER_GO     = 8'hD0;
  localparam logic [7:0] CMD_STATUS    = 8'h70;
  localparam logic [7:0] CMD_IDENT     = 8'h90;
  localparam logic [7:0] CMD_RESET     = 8'hFF;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_READ     = 4'd1,
    OP_READ_CB  = 4'd2,
    OP_PROG     = 4'd3,
    OP_CACHE    = 4'd4,
    OP_COPY     = 4'd5,
    OP_ERASE    = 4'd6,
    OP_RAND_IN  = 4'd7,
    OP_RAND_OUT = 4'd8,
    OP_RESET    = 4'd9
  } opKind_e;

  typedef enum logic [1:0] {
    OUT_NONE,
    OUT_STATUS,
    OUT_IDENT
  } outMode_e;

  typedef struct packed {
    logic              addrWe;
    logic [SLOT_W-1:0] addrSlot;
    logic              fire;
    opKind_e           fireKind;
    logic              doReset;
    logic              setStatus;
    logic              setIdent;
    logic              clrOut;
  } ctrlStrobe_t;

endpackage

// File: rtl/nand_cmd_ctrl.sv
module nand_cmd_ctrl
  import nand_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        weRise,
  input  logic        isCmd,
  input  logic        isAddr,
  input  logic        busy,
  input  logic [7:0]  ioByte,
  output ctrlStrobe_t stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_CONF} state_e;
  typedef enum logic [2:0] {
    SQ_READ, SQ_PROG, SQ_COPY, SQ_RIN, SQ_ROUT, SQ_ERASE, SQ_IDENT
  } seq_e;

  state_e            state, stateN;
  seq_e              seq, seqN, newSeq;
  logic [SLOT_W-1:0] cnt, cntN;
  logic              goNew;

  function automatic logic [SLOT_W-1:0] needOf(seq_e s);
    case (s)
      SQ_RIN, SQ_ROUT: needOf = SLOT_W'(COL_BYTES);
      SQ_ERASE:        needOf = SLOT_W'(ROW_BYTES);
      SQ_IDENT:        needOf = SLOT_W'(1);
      default:         needOf = SLOT_W'(ADDR_BYTES);
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] startOf(seq_e s);
    startOf = (s == SQ_ERASE) ? SLOT_W'(COL_BYTES) : '0;
  endfunction

  always_comb begin
    stb    = '0;
    stateN = state;
    seqN   = seq;
    cntN   = cnt;
    goNew  = 1'b0;
    newSeq = SQ_READ;

    if (weRise && isCmd) begin
      if (ioByte == CMD_RESET) begin
        stb.doReset = 1'b1;
        stateN      = ST_IDLE;
      end else if (ioByte == CMD_STATUS) begin
        stb.setStatus = 1'b1;
      end else if (!busy) begin
        case (state)
          ST_IDLE: begin
            goNew = 1'b1;
            case (ioByte)
              CMD_RD_SETUP: newSeq = SQ_READ;
              CMD_PG_SETUP: newSeq = SQ_PROG;
              CMD_COL_IN:   newSeq = SQ_COPY;
              CMD_COL_OUT:  newSeq = SQ_ROUT;
              CMD_ER_SETUP: newSeq = SQ_ERASE;
              CMD_IDENT:    newSeq = SQ_IDENT;
              default:      goNew  = 1'b0;
            endcase
          end
          ST_ADDR: begin
            stb.clrOut = 1'b1;
            stateN     = ST_IDLE;
          end
          default: begin
            stb.clrOut = 1'b1;
            stateN     = ST_IDLE;
            case (seq)
              SQ_READ: begin
                if (ioByte == CMD_RD_GO) begin
                  stb.fire = 1'b1; stb.fireKind = OP_READ;
                end else if (ioByte == CMD_RD_CB_GO) begin
                  stb.fire = 1'b1; stb.fireKind = OP_READ_CB;
                end
              end
              SQ_PROG: begin
                if (ioByte == CMD_PG_GO) begin
                  stb.fire = 1'b1; stb.fireKind = OP_PROG;
                end else if (ioByte == CMD_PG_CACHE) begin
                  stb.fire = 1'b1; stb.fireKind = OP_CACHE;
                end else if (ioByte == CMD_COL_IN) begin
                  goNew = 1'b1; newSeq = SQ_RIN;
                end
              end
              SQ_COPY: begin
                if (ioByte == CMD_PG_GO) begin
                  stb.fire = 1'b1; stb.fireKind = OP_COPY;
                end
              end
              SQ_ROUT: begin
                if (ioByte == CMD_COL_OUTGO) begin
                  stb.fire = 1'b1; stb.fireKind = OP_RAND_OUT;
                end
              end
              SQ_ERASE: begin
                if (ioByte == CMD_ER_GO) begin
                  stb.fire = 1'b1; stb.fireKind = OP_ERASE;
                end
              end
              default: ;
            endcase
          end
        endcase
      end
    end else if (weRise && isAddr && !busy && state == ST_ADDR) begin
      stb.addrWe   = (seq != SQ_IDENT);
      stb.addrSlot = startOf(seq) + cnt;
      if (cnt == needOf(seq) - SLOT_W'(1)) begin
        case (seq)
          SQ_IDENT: begin
            stb.setIdent = 1'b1;
            stateN       = ST_IDLE;
          end
          SQ_RIN: begin
            stb.fire     = 1'b1;
            stb.fireKind = OP_RAND_IN;
            stateN       = ST_CONF;
            seqN         = SQ_PROG;
          end
          default: stateN = ST_CONF;
        endcase
      end else begin
        cntN = cnt + SLOT_W'(1);
      end
    end

    if (goNew) begin
      stb.clrOut = 1'b1;
      stateN     = ST_ADDR;
      seqN       = newSeq;
      cntN       = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      seq   <= SQ_READ;
      cnt   <= '0;
    end else begin
      state <= stateN;
      seq   <= seqN;
      cnt   <= cntN;
    end
  end

endmodule

// File: rtl/nand_cmd_dp.sv
module nand_cmd_dp
  import nand_cmd_pkg::*;
#(
  parameter int              COL_MAX    = 2111,
  parameter int              ROW_MAX    = 131071,
  parameter int              BUSY_READ  = 20,
  parameter int              BUSY_PROG  = 40,
  parameter int              BUSY_CACHE = 8,
  parameter int              BUSY_ERASE = 60,
  parameter int              BUSY_RESET = 5,
  parameter int              ID_BYTES   = 4,
  parameter logic [8*ID_BYTES-1:0] ID_CODE = 32'h9510DAA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             weN,
  input  logic             reN,
  input  logic [7:0]       ioByte,
  input  ctrlStrobe_t      stb,
  output logic             weRise,
  output logic             busy,
  output logic [7:0]       dataOut,
  output logic             opValid,
  output opKind_e          opKind,
  output logic [COL_W-1:0] colAddr,
  output logic [ROW_W-1:0] rowAddr,
  output logic             addrErr
);

  localparam int BUSY_TOP1 = (BUSY_READ > BUSY_PROG) ? BUSY_READ : BUSY_PROG;
  localparam int BUSY_TOP2 = (BUSY_CACHE > BUSY_ERASE) ? BUSY_CACHE : BUSY_ERASE;
  localparam int BUSY_TOP3 = (BUSY_TOP1 > BUSY_TOP2) ? BUSY_TOP1 : BUSY_TOP2;
  localparam int BUSY_TOP  = (BUSY_TOP3 > BUSY_RESET) ? BUSY_TOP3 : BUSY_RESET;
  localparam int CNT_W     = $clog2(BUSY_TOP + 1);
  localparam int IDX_W     = (ID_BYTES > 2) ? $clog2(ID_BYTES) : 1;
  localparam logic [COL_W-1:0] COL_LIM = COL_W'(COL_MAX);
  localparam logic [ROW_W-1:0] ROW_LIM = ROW_W'(ROW_MAX);

  logic              wePrev, rePrev, reRise;
  logic [ADDR_W-1:0] addrReg, addrNext;
  logic [COL_W-1:0]  colNext;
  logic [ROW_W-1:0]  rowNext;
  logic [CNT_W-1:0]  busyCnt;
  logic              failFlag, rangeOk;
  outMode_e          outMode;
  logic [IDX_W-1:0]  idIdx;
  logic [7:0]        statusByte;

  function automatic logic [CNT_W-1:0] busyOf(opKind_e k);
    case (k)
      OP_READ, OP_READ_CB: busyOf = CNT_W'(BUSY_READ);
      OP_PROG, OP_COPY:    busyOf = CNT_W'(BUSY_PROG);
      OP_CACHE:            busyOf = CNT_W'(BUSY_CACHE);
      OP_ERASE:            busyOf = CNT_W'(BUSY_ERASE);
      default:             busyOf = '0;
    endcase
  endfunction

  assign weRise = weN && !wePrev && !ceN;
  assign reRise = reN && !rePrev && !ceN;
  assign busy   = (busyCnt != '0);

  always_comb begin
    addrNext = addrReg;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (stb.addrWe && stb.addrSlot == SLOT_W'(b)) addrNext[b*8 +: 8] = ioByte;
    end
  end

  assign colNext = addrNext[COL_W-1:0];
  assign rowNext = addrNext[ADDR_W-1:COL_W];

  always_comb begin
    case (stb.fireKind)
      OP_ERASE:              rangeOk = (rowNext <= ROW_LIM);
      OP_RAND_IN, OP_RAND_OUT: rangeOk = (colNext <= COL_LIM);
      default:               rangeOk = (colNext <= COL_LIM) && (rowNext <= ROW_LIM);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wePrev   <= 1'b1;
      rePrev   <= 1'b1;
      addrReg  <= '0;
      busyCnt  <= '0;
      failFlag <= 1'b0;
      opValid  <= 1'b0;
      opKind   <= OP_NONE;
    end else begin
      wePrev  <= weN;
      rePrev  <= reN;
      addrReg <= addrNext;
      opValid <= 1'b0;
      if (busy) busyCnt <= busyCnt - CNT_W'(1);
      if (stb.doReset) begin
        opValid  <= 1'b1;
        opKind   <= OP_RESET;
        busyCnt  <= CNT_W'(BUSY_RESET);
        failFlag <= 1'b0;
      end else if (stb.fire) begin
        if (rangeOk) begin
          opValid  <= 1'b1;
          opKind   <= stb.fireKind;
          busyCnt  <= busyOf(stb.fireKind);
          failFlag <= 1'b0;
        end else begin
          failFlag <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outMode <= OUT_NONE;
      idIdx   <= '0;
    end else if (stb.doReset || stb.clrOut) begin
      outMode <= OUT_NONE;
    end else if (stb.setStatus) begin
      outMode <= OUT_STATUS;
    end else if (stb.setIdent) begin
      outMode <= OUT_IDENT;
      idIdx   <= '0;
    end else if (reRise && outMode == OUT_IDENT) begin
      idIdx <= (idIdx == IDX_W'(ID_BYTES - 1)) ? '0 : idIdx + IDX_W'(1);
    end
  end

  assign statusByte = {1'b0, !busy, 5'b0, failFlag};

  always_comb begin
    case (outMode)
      OUT_STATUS: dataOut = statusByte;
      OUT_IDENT:  dataOut = ID_CODE[idIdx*8 +: 8];
      default:    dataOut = 8'h00;
    endcase
  end

  assign colAddr = addrReg[COL_W-1:0];
  assign rowAddr = addrReg[ADDR_W-1:COL_W];
  assign addrErr = failFlag;

endmodule

// File: rtl/nand_cmd_top.sv
module nand_cmd_top
  import nand_cmd_pkg::*;
#(
  parameter int              COL_MAX    = 2111,
  parameter int              ROW_MAX    = 131071,
  parameter int              BUSY_READ  = 20,
  parameter int              BUSY_PROG  = 40,
  parameter int              BUSY_CACHE = 8,
  parameter int              BUSY_ERASE = 60,
  parameter int              BUSY_RESET = 5,
  parameter int              ID_BYTES   = 4,
  parameter logic [8*ID_BYTES-1:0] ID_CODE = 32'h9510DAA5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        cleIn,
  input  logic        aleIn,
  input  logic        weN,
  input  logic        reN,
  input  logic [7:0]  ioIn,
  output logic [7:0]  dataOut,
  output logic        rdyBusyN,
  output logic        opValid,
  output logic [3:0]  opKind,
  output logic [15:0] colAddr,
  output logic [23:0] rowAddr,
  output logic        addrErr
);

  ctrlStrobe_t stb;
  logic        weRise, busy, isCmd, isAddr;
  opKind_e     kindE;

  assign isCmd  = cleIn && !aleIn;
  assign isAddr = aleIn && !cleIn;

  nand_cmd_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .weRise (weRise),
    .isCmd  (isCmd),
    .isAddr (isAddr),
    .busy   (busy),
    .ioByte (ioIn),
    .stb    (stb)
  );

  nand_cmd_dp #(
    .COL_MAX    (COL_MAX),
    .ROW_MAX    (ROW_MAX),
    .BUSY_READ  (BUSY_READ),
    .BUSY_PROG  (BUSY_PROG),
    .BUSY_CACHE (BUSY_CACHE),
    .BUSY_ERASE (BUSY_ERASE),
    .BUSY_RESET (BUSY_RESET),
    .ID_BYTES   (ID_BYTES),
    .ID_CODE    (ID_CODE)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .weN     (weN),
    .reN     (reN),
    .ioByte  (ioIn),
    .stb     (stb),
    .weRise  (weRise),
    .busy    (busy),
    .dataOut (dataOut),
    .opValid (opValid),
    .opKind  (kindE),
    .colAddr (colAddr),
    .rowAddr (rowAddr),
    .addrErr (addrErr)
  );

  assign opKind   = kindE;
  assign rdyBusyN = !busy;

endmodule

// File: rtl/nand_cmd_chk.sv
module nand_cmd_chk
  import nand_cmd_pkg::*;
#(
  parameter int COL_MAX = 2111,
  parameter int ROW_MAX = 131071
) (
  input logic        clk,
  input logic        rstN,
  input logic        ceN,
  input logic        cleIn,
  input logic        aleIn,
  input logic        rdyBusyN,
  input logic        opValid,
  input logic [3:0]  opKind,
  input logic [15:0] colAddr,
  input logic [23:0] rowAddr
);

  localparam logic [15:0] COL_LIM = 16'(COL_MAX);
  localparam logic [23:0] ROW_LIM = 24'(ROW_MAX);

  AST_CONFIRM_IS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind != 4'(OP_RAND_IN)) |-> $past(cleIn && !aleIn && !ceN)); // R1

  AST_RAND_ROW_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 4'(OP_RAND_OUT)) |-> (rowAddr == $past(rowAddr))); // R4

  AST_BUSY_ONLY_RESET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!rdyBusyN) && opValid) |-> (opKind == 4'(OP_RESET))); // R6

  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind != 4'(OP_RESET) && opKind != 4'(OP_ERASE)) |-> (colAddr <= COL_LIM)); // R9

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind != 4'(OP_RESET) && opKind != 4'(OP_RAND_IN)
     && opKind != 4'(OP_RAND_OUT)) |-> (rowAddr <= ROW_LIM)); // R9

  AST_BUSY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyBusyN) |-> opValid); // R12

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid); // R12

endmodule

bind nand_cmd_top nand_cmd_chk #(.COL_MAX(COL_MAX), .ROW_MAX(ROW_MAX)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .cleIn    (cleIn),
  .aleIn    (aleIn),
  .rdyBusyN (rdyBusyN),
  .opValid  (opValid),
  .opKind   (opKind),
  .colAddr  (colAddr),
  .rowAddr  (rowAddr)
);

// File: tb/tb_nand_cmd_top.sv
`timescale 1ns/1ps
module tb_nand_cmd_top;

  localparam int COL_MAX = 2111;
  localparam int ROW_MAX = 131071;
  localparam int B_READ  = 20;
  localparam int B_PROG  = 40;
  localparam int B_CACHE = 8;
  localparam int B_ERASE = 60;
  localparam int B_RESET = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b0, cleIn = 1'b0, aleIn = 1'b0, weN = 1'b1, reN = 1'b1;
  logic [7:0]  ioIn = 8'h00;
  logic [7:0]  dataOut;
  logic        rdyBusyN, opValid, addrErr;
  logic [3:0]  opKind;
  logic [15:0] colAddr;
  logic [23:0] rowAddr;

  int nChecks = 0;
  int nFail   = 0;
  int strobeCnt = 0;
  logic [15:0] mCol = '0;
  logic [23:0] mRow = '0;

  always #2 clk = ~clk;

  nand_cmd_top #(
    .COL_MAX(COL_MAX), .ROW_MAX(ROW_MAX), .BUSY_READ(B_READ), .BUSY_PROG(B_PROG),
    .BUSY_CACHE(B_CACHE), .BUSY_ERASE(B_ERASE), .BUSY_RESET(B_RESET),
    .ID_BYTES(4), .ID_CODE(32'h9510DAA5)
  ) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cleIn(cleIn), .aleIn(aleIn), .weN(weN),
    .reN(reN), .ioIn(ioIn), .dataOut(dataOut), .rdyBusyN(rdyBusyN), .opValid(opValid),
    .opKind(opKind), .colAddr(colAddr), .rowAddr(rowAddr), .addrErr(addrErr)
  );

  always @(posedge clk) if (rstN && opValid) strobeCnt <= strobeCnt + 1;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busCycle(input logic c, input logic a, input logic [7:0] b);
    cleIn = c; aleIn = a; ioIn = b; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    cleIn = 1'b0; aleIn = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);  busCycle(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b);  busCycle(1'b0, 1'b1, b); endtask
  task automatic dat(input logic [7:0] b);  busCycle(1'b0, 1'b0, b); endtask

  task automatic readByte(output logic [7:0] v);
    reN = 1'b0;
    @(negedge clk);
    v = dataOut;
    reN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (!rdyBusyN && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] setupOf(int op);
    case (op)
      0, 1:    return 8'h00;
      2, 3:    return 8'h80;
      4:       return 8'h85;
      default: return 8'h60;
    endcase
  endfunction

  function automatic logic [7:0] confOf(int op);
    case (op)
      0:       return 8'h30;
      1:       return 8'h35;
      2, 4:    return 8'h10;
      3:       return 8'h15;
      default: return 8'hD0;
    endcase
  endfunction

  function automatic int kindOf(int op);
    case (op)
      0: return 1;  1: return 2;  2: return 3;
      3: return 4;  4: return 5;  default: return 6;
    endcase
  endfunction

  function automatic int busyOf(int op);
    case (op)
      0, 1:    return B_READ;
      2, 4:    return B_PROG;
      3:       return B_CACHE;
      default: return B_ERASE;
    endcase
  endfunction

  // Full array operation with bench-side expectation (R2, R3, R5, R9, R12)
  task automatic doOp(input int op, input logic [15:0] c, input logic [23:0] r);
    logic ok;
    int   n;
    cmd(setupOf(op));
    if (op != 5) begin
      adr(c[7:0]); adr(c[15:8]); mCol = c;
    end
    adr(r[7:0]); adr(r[15:8]); adr(r[23:16]); mRow = r;
    if (op == 2 || op == 3) begin dat(8'h5A); dat(8'hC3); end
    cmd(confOf(op));
    ok = (op == 5) ? (r <= 24'(ROW_MAX)) : (c <= 16'(COL_MAX) && r <= 24'(ROW_MAX));
    if (ok) begin
      check("R2/R3/R5", "strobe", 32'(opValid), 32'd1);
      check("R2/R3/R5", "kind", 32'(opKind), 32'(kindOf(op)));
      check("R2", "column", 32'(colAddr), 32'(mCol));
      check("R2", "row", 32'(rowAddr), 32'(mRow));
      waitReady(n);
      check("R12", "busy length", 32'(n), 32'(busyOf(op)));
      check("R9", "error clear", 32'(addrErr), 32'd0);
    end else begin
      check("R9", "no strobe when out of range", 32'(opValid), 32'd0);
      check("R9", "no busy when out of range", 32'(rdyBusyN), 32'd1);
      check("R9", "error set", 32'(addrErr), 32'd1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int         n, base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R12", "reset ready", 32'(rdyBusyN), 32'd1);
    check("R12", "reset strobe", 32'(opValid), 32'd0);
    check("R9", "reset error", 32'(addrErr), 32'd0);
    check("R11", "reset dataOut", 32'(dataOut), 32'd0);

    // R1: ignored captures
    ceN = 1'b1; cmd(8'h70); ceN = 1'b0;
    readByte(v);
    check("R1", "status with CE high ignored", 32'(v), 32'h00);
    busCycle(1'b1, 1'b1, 8'h70);
    readByte(v);
    check("R1", "both latch enables ignored", 32'(v), 32'h00);
    cmd(8'h70);
    readByte(v);
    check("R10", "status ready", 32'(v), 32'h40);

    // R2/R3/R5 directed
    doOp(0, 16'd2111, 24'd131071);
    doOp(1, 16'd0, 24'd0);
    doOp(2, 16'd64, 24'd300);
    doOp(3, 16'd65, 24'd301);
    doOp(4, 16'd7, 24'd77);
    doOp(5, 16'd0, 24'd1234);
    check("R5", "erase keeps column", 32'(colAddr), 32'd7);

    // R7: undefined opcode in idle, stray address and confirm
    @(negedge clk); base = strobeCnt;
    cmd(8'h33); adr(8'h01); adr(8'h00); adr(8'h02); adr(8'h00); adr(8'h00); cmd(8'h30);
    repeat (2) @(negedge clk);
    check("R7", "undefined opcode no strobe", 32'(strobeCnt - base), 32'd0);
    check("R7", "undefined opcode no busy", 32'(rdyBusyN), 32'd1);

    // R7: early confirm aborts
    cmd(8'h00); adr(8'h10); adr(8'h00); cmd(8'h30);
    adr(8'h05); adr(8'h00); adr(8'h00); cmd(8'h30);
    repeat (2) @(negedge clk);
    check("R7", "early confirm aborts", 32'(strobeCnt - base), 32'd0);

    // R4: random output keeps row
    doOp(0, 16'd100, 24'd7);
    cmd(8'h05); adr(8'h2C); adr(8'h01); cmd(8'hE0);
    check("R4", "random out strobe", 32'(opValid), 32'd1);
    check("R4", "random out kind", 32'(opKind), 32'd8);
    check("R4", "random out column", 32'(colAddr), 32'd300);
    check("R4", "random out row kept", 32'(rowAddr), 32'd7);
    check("R4", "random out no busy", 32'(rdyBusyN), 32'd1);

    // R4: random input inside program
    cmd(8'h80); adr(8'h0A); adr(8'h00); adr(8'h09); adr(8'h00); adr(8'h00);
    dat(8'h11); cmd(8'h85); adr(8'h20); adr(8'h00);
    check("R4", "random in strobe", 32'(opValid), 32'd1);
    check("R4", "random in kind", 32'(opKind), 32'd7);
    check("R4", "random in column", 32'(colAddr), 32'h20);
    check("R4", "random in row kept", 32'(rowAddr), 32'd9);
    dat(8'h22); cmd(8'h10);
    check("R4", "program after random in", 32'(opKind), 32'd3);
    check("R4", "program column", 32'(colAddr), 32'h20);
    waitReady(n);
    check("R12", "program busy", 32'(n), 32'(B_PROG));

    // R6 / R10: commands during busy
    cmd(8'h60); adr(8'h03); adr(8'h00); adr(8'h00); cmd(8'hD0);
    check("R5", "erase strobe", 32'(opKind), 32'd6);
    @(negedge clk); base = strobeCnt;
    cmd(8'h00); adr(8'h01); adr(8'h00); adr(8'h01); adr(8'h00); adr(8'h00); cmd(8'h30);
    check("R6", "read ignored while busy", 32'(strobeCnt - base), 32'd0);
    cmd(8'h70);
    readByte(v);
    check("R10", "status while busy", 32'(v), 32'h00);
    waitReady(n);
    readByte(v);
    check("R10", "status after ready", 32'(v), 32'h40);
    check("R6", "row untouched while busy", 32'(rowAddr), 32'd3);

    // R8: reset mid sequence and during busy
    cmd(8'h80); adr(8'h01); adr(8'h00); cmd(8'hFF);
    check("R8", "reset strobe", 32'(opValid), 32'd1);
    check("R8", "reset kind", 32'(opKind), 32'd9);
    waitReady(n);
    check("R8", "reset busy", 32'(n), 32'(B_RESET));
    @(negedge clk); base = strobeCnt;
    adr(8'h01); adr(8'h00); adr(8'h00); cmd(8'h10);
    repeat (2) @(negedge clk);
    check("R8", "sequence aborted by reset", 32'(strobeCnt - base), 32'd0);
    cmd(8'h60); adr(8'h04); adr(8'h00); adr(8'h00); cmd(8'hD0);
    repeat (5) @(negedge clk);
    cmd(8'hFF);
    check("R8", "reset during busy kind", 32'(opKind), 32'd9);
    waitReady(n);
    check("R8", "reset during busy length", 32'(n), 32'(B_RESET));

    // R9: out of range, status bit 0
    doOp(0, 16'd2112, 24'd5);
    cmd(8'h70);
    readByte(v);
    check("R10", "status shows failure", 32'(v), 32'h41);
    doOp(0, 16'd0, 24'd131072);
    doOp(5, 16'd0, 24'd131072);
    doOp(5, 16'd0, 24'd131071);

    // R11: identification with wrap
    cmd(8'h90); adr(8'h00);
    readByte(v); check("R11", "id byte 0", 32'(v), 32'hA5);
    readByte(v); check("R11", "id byte 1", 32'(v), 32'hDA);
    readByte(v); check("R11", "id byte 2", 32'(v), 32'h10);
    readByte(v); check("R11", "id byte 3", 32'(v), 32'h95);
    readByte(v); check("R11", "id wrap", 32'(v), 32'hA5);

    // R10: persistence and clearing
    cmd(8'h70);
    readByte(v); check("R10", "status pulse 1", 32'(v), 32'h40);
    readByte(v); check("R10", "status pulse 2", 32'(v), 32'h40);
    cmd(8'h00);
    readByte(v); check("R10", "status cleared by command", 32'(v), 32'h00);
    cmd(8'hFF);
    waitReady(n);

    // random mix
    doOp(0, 16'd1, 24'd1);
    for (int i = 0; i < 30; i++) begin
      int          op;
      logic [15:0] c;
      logic [23:0] r;
      op = int'($urandom % 6);
      c  = 16'($urandom % 2200);
      r  = 24'($urandom % 135000);
      if (i % 5 == 0) c = 16'(COL_MAX + (i % 2));
      if (i % 7 == 0) r = 24'(ROW_MAX + (i % 2));
      doOp(op, c, r);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule